// File: doc/BRIEF.md
# Synchronising Register File with Continuations

This block is a multi-ported register file for a multithreaded pipeline in which every register carries a two-bit state tag next to its data word. A register holds either a value or a continuation in the same storage. The continuation is either the index of a suspended local thread or the address of a remote register that is waiting for the value. A read that finds no data parks its requester in the register. The write that later fills the register either wakes the parked thread or forwards the value to the remote requester. Synchronisation therefore costs a single cycle and needs no memory round trip.

The pipeline sees a local read port and a writeback port. The writeback port can store data or mark a register as pending, for example for a cache-missing load or a variable-latency operation. Memory, long-latency units and family-create events deliver their results through an asynchronous write port. Neighbouring processors use a remote-read request port. The thread scheduler is seen only through a registered wake-up output that carries a thread index. Forwarded values leave through a registered forward output that carries the destination address.

The register space holds `NUM_CTX` contexts of `CTX_REGS` registers each. The register address is `{context, index}`. The last index of each context is a constant zero register.

Top module: `srf_top`

## Requirements
- R1: After reset every register except the zero registers is empty: a local read returns `rd_suspend`=1, `rd_ok`=0 and `rd_data`=0.
- R2: A local read of a full register asserts `rd_ok` and returns its data combinationally, in the same cycle.
- R3: A local read of an empty register asserts `rd_suspend` and stores `rd_tid` in the register, which becomes a thread continuation. The next data write to that register makes it full. In the cycle after that write, `wake_v`=1 and `wake_tid` carries the stored index.
- R4: A remote read of an empty register stores `rr_dest` and asserts neither `rr_ok` nor `rr_err`. The next data write makes the register full. In the cycle after that write, `fwd_v`=1, `fwd_dest` carries the stored address and `fwd_data` carries the written value.
- R5: A remote read of a full register asserts `rr_ok` and returns the data in the same cycle.
- R6: A writeback with `wb_empty`=1 turns a full register empty. A later write on the asynchronous port fills it.
- R7: The writeback always wins a conflict with the asynchronous write, which is then held for one cycle and applied afterwards while `aw_held`=1. A conflict is either the same address, or both writes landing on continuation registers in the same cycle. The asynchronous source issues no write while `aw_held`=1.
- R8: A local read of a register that already holds a continuation asserts `rd_err`, and the stored continuation is kept. A remote read of such a register asserts `rr_err`.
- R9: Index `CTX_REGS-1` of every context reads as full with value 0 on both read ports, and writes to it are ignored.
- R10: A read in the same cycle as a data write to the same register sees the written value as full. No continuation is stored and nothing is woken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Local read request |
| rd_addr | input | ADDR_W | Local read register address |
| rd_tid | input | TID_W | Thread index of the reader |
| rd_data | output | DATA_W | Read data, 0 unless `rd_ok` |
| rd_ok | output | 1 | Register was full, data valid |
| rd_suspend | output | 1 | Register was empty, reader parked |
| rd_err | output | 1 | Register already held a continuation |
| rr_en | input | 1 | Remote read request |
| rr_addr | input | ADDR_W | Remote read register address |
| rr_dest | input | RADDR_W | Remote register awaiting the value |
| rr_ok | output | 1 | Remote read answered at once |
| rr_data | output | DATA_W | Remote read data, 0 unless `rr_ok` |
| rr_err | output | 1 | Remote read rejected, register occupied |
| wb_en | input | 1 | Pipeline writeback |
| wb_addr | input | ADDR_W | Writeback register address |
| wb_empty | input | 1 | Writeback marks the register pending instead of writing data |
| wb_data | input | DATA_W | Writeback data |
| aw_en | input | 1 | Asynchronous write |
| aw_addr | input | ADDR_W | Asynchronous write address |
| aw_data | input | DATA_W | Asynchronous write data |
| aw_held | output | 1 | An asynchronous write is being held this cycle |
| wake_v | output | 1 | Reschedule request |
| wake_tid | output | TID_W | Thread to reschedule |
| fwd_v | output | 1 | Forward a value to a remote register |
| fwd_dest | output | RADDR_W | Remote register address |
| fwd_data | output | DATA_W | Forwarded value |

## Verification
The hardest situation to reach is a collision between the two write paths. In one form, the writeback and the asynchronous port target the same register. In the other, they target two different registers that both hold parked threads, so two wake-ups compete for one output. The stimulus first parks two threads with separate local reads, then fires the writeback and the asynchronous write in the same cycle. It expects the two wake-ups to come out in consecutive cycles, writeback first. A same-address clash is checked both through the bypassed read value in the clash cycle and through the final register contents.

// File: rtl/srf_pkg.sv
package srf_pkg;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_FULL  = 2'd1,
    ST_TCONT = 2'd2,
    ST_RCONT = 2'd3
  } reg_state_e;

  function automatic logic is_cont(reg_state_e s);
    return (s == ST_TCONT) || (s == ST_RCONT);
  endfunction

endpackage

// File: rtl/srf_cell.sv
module srf_cell
  import srf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_en,
  input  logic              lr_en,
  input  logic [DATA_W-1:0] lr_tag,
  input  logic              rr_en,
  input  logic [DATA_W-1:0] rr_tag,
  output reg_state_e        cur_st,
  output logic [DATA_W-1:0] cur_d,
  output reg_state_e        eff_st,
  output logic [DATA_W-1:0] eff_d
);

  reg_state_e        st_q, st_d;
  logic [DATA_W-1:0] d_q, d_d;
  logic              d_load;

  always_comb begin
    eff_st = st_q;
    eff_d  = d_q;
    if (wr_en) begin
      eff_st = ST_FULL;
      eff_d  = wr_data;
    end else if (clr_en && !is_cont(st_q)) begin
      eff_st = ST_EMPTY;
    end
    st_d   = eff_st;
    d_d    = eff_d;
    d_load = wr_en;
    if (eff_st == ST_EMPTY) begin
      if (lr_en) begin
        st_d   = ST_TCONT;
        d_d    = lr_tag;
        d_load = 1'b1;
      end else if (rr_en) begin
        st_d   = ST_RCONT;
        d_d    = rr_tag;
        d_load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_EMPTY;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (d_load) d_q <= d_d;
  end

  assign cur_st = st_q;
  assign cur_d  = d_q;

endmodule

// File: rtl/srf_aw_hold.sv
module srf_aw_hold #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_en,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [DATA_W-1:0] aw_data,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_evt,
  input  logic              cand_cont,
  output logic [ADDR_W-1:0] cand_addr,
  output logic              app_v,
  output logic [ADDR_W-1:0] app_addr,
  output logic [DATA_W-1:0] app_data,
  output logic              held
);

  logic              held_q, held_d;
  logic [ADDR_W-1:0] h_addr_q;
  logic [DATA_W-1:0] h_data_q;
  logic              cand_v, clash, h_load;
  logic [DATA_W-1:0] cand_data;

  always_comb begin
    cand_v    = held_q | aw_en;
    cand_addr = held_q ? h_addr_q : aw_addr;
    cand_data = held_q ? h_data_q : aw_data;
    clash     = cand_v && wb_en &&
                ((wb_addr == cand_addr) || (wb_evt && cand_cont));
    app_v     = cand_v && !clash;
    held_d    = cand_v && clash;
    h_load    = held_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= held_d;
  end

  always_ff @(posedge clk) begin
    if (h_load) begin
      h_addr_q <= cand_addr;
      h_data_q <= cand_data;
    end
  end

  assign app_addr = cand_addr;
  assign app_data = cand_data;
  assign held     = held_q;

endmodule

// File: rtl/srf_evt.sv
module srf_evt #(
  parameter int DATA_W  = 32,
  parameter int TID_W   = 6,
  parameter int RADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_v,
  input  logic               ev_remote,
  input  logic [TID_W-1:0]   ev_tid,
  input  logic [RADDR_W-1:0] ev_dest,
  input  logic [DATA_W-1:0]  ev_data,
  output logic               wake_v,
  output logic [TID_W-1:0]   wake_tid,
  output logic               fwd_v,
  output logic [RADDR_W-1:0] fwd_dest,
  output logic [DATA_W-1:0]  fwd_data
);

  logic wake_d, fwd_d;

  always_comb begin
    wake_d = ev_v && !ev_remote;
    fwd_d  = ev_v && ev_remote;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_v <= 1'b0;
      fwd_v  <= 1'b0;
    end else begin
      wake_v <= wake_d;
      fwd_v  <= fwd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wake_d) wake_tid <= ev_tid;
    if (fwd_d) begin
      fwd_dest <= ev_dest;
      fwd_data <= ev_data;
    end
  end

endmodule

// File: rtl/srf_top.sv
module srf_top
  import srf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_CTX  = 4,
  parameter int CTX_REGS = 32,
  parameter int TID_W    = 6,
  parameter int RADDR_W  = 16,
  parameter int ADDR_W   = $clog2(NUM_CTX * CTX_REGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [TID_W-1:0]   rd_tid,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_ok,
  output logic               rd_suspend,
  output logic               rd_err,
  input  logic               rr_en,
  input  logic [ADDR_W-1:0]  rr_addr,
  input  logic [RADDR_W-1:0] rr_dest,
  output logic               rr_ok,
  output logic [DATA_W-1:0]  rr_data,
  output logic               rr_err,
  input  logic               wb_en,
  input  logic [ADDR_W-1:0]  wb_addr,
  input  logic               wb_empty,
  input  logic [DATA_W-1:0]  wb_data,
  input  logic               aw_en,
  input  logic [ADDR_W-1:0]  aw_addr,
  input  logic [DATA_W-1:0]  aw_data,
  output logic               aw_held,
  output logic               wake_v,
  output logic [TID_W-1:0]   wake_tid,
  output logic               fwd_v,
  output logic [RADDR_W-1:0] fwd_dest,
  output logic [DATA_W-1:0]  fwd_data
);

  localparam int NREG     = NUM_CTX * CTX_REGS;
  localparam int ZERO_IDX = CTX_REGS - 1;

  reg_state_e        cur_st [NREG];
  logic [DATA_W-1:0] cur_d  [NREG];
  reg_state_e        eff_st [NREG];
  logic [DATA_W-1:0] eff_d  [NREG];

  logic              wb_evt, as_evt, ev_v, ev_remote, cand_cont;
  logic              app_v;
  logic [ADDR_W-1:0] cand_addr, app_addr, ev_addr;
  logic [DATA_W-1:0] app_data, ev_data;
  logic [DATA_W-1:0] lr_tag, rr_tag;

  assign lr_tag = {{(DATA_W-TID_W){1'b0}}, rd_tid};
  assign rr_tag = {{(DATA_W-RADDR_W){1'b0}}, rr_dest};

  always_comb begin
    wb_evt    = wb_en && !wb_empty && is_cont(cur_st[wb_addr]);
    cand_cont = is_cont(cur_st[cand_addr]);
    as_evt    = app_v && is_cont(cur_st[app_addr]);
    ev_v      = wb_evt || as_evt;
    ev_addr   = wb_evt ? wb_addr : app_addr;
    ev_data   = wb_evt ? wb_data : app_data;
    ev_remote = (cur_st[ev_addr] == ST_RCONT);
  end

  srf_aw_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .aw_en     (aw_en),
    .aw_addr   (aw_addr),
    .aw_data   (aw_data),
    .wb_en     (wb_en),
    .wb_addr   (wb_addr),
    .wb_evt    (wb_evt),
    .cand_cont (cand_cont),
    .cand_addr (cand_addr),
    .app_v     (app_v),
    .app_addr  (app_addr),
    .app_data  (app_data),
    .held      (aw_held)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if ((g % CTX_REGS) == ZERO_IDX) begin : g_zero
      assign cur_st[g] = ST_FULL;
      assign cur_d[g]  = '0;
      assign eff_st[g] = ST_FULL;
      assign eff_d[g]  = '0;
    end else begin : g_cell
      logic wb_hit, wr_en, as_hit;
      logic [DATA_W-1:0] wr_data;
      assign wb_hit  = wb_en && (wb_addr == ADDR_W'(g));
      assign as_hit  = app_v && (app_addr == ADDR_W'(g));
      assign wr_en   = (wb_hit && !wb_empty) || as_hit;
      assign wr_data = (wb_hit && !wb_empty) ? wb_data : app_data;
      srf_cell #(.DATA_W(DATA_W)) i_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .clr_en  (wb_hit && wb_empty),
        .lr_en   (rd_en && (rd_addr == ADDR_W'(g))),
        .lr_tag  (lr_tag),
        .rr_en   (rr_en && (rr_addr == ADDR_W'(g))),
        .rr_tag  (rr_tag),
        .cur_st  (cur_st[g]),
        .cur_d   (cur_d[g]),
        .eff_st  (eff_st[g]),
        .eff_d   (eff_d[g])
      );
    end
  end

  always_comb begin
    rd_ok      = rd_en && (eff_st[rd_addr] == ST_FULL);
    rd_suspend = rd_en && (eff_st[rd_addr] == ST_EMPTY);
    rd_err     = rd_en && is_cont(eff_st[rd_addr]);
    rd_data    = rd_ok ? eff_d[rd_addr] : '0;
    rr_ok      = rr_en && (eff_st[rr_addr] == ST_FULL);
    rr_err     = rr_en && (is_cont(eff_st[rr_addr]) ||
                 ((eff_st[rr_addr] == ST_EMPTY) && rd_en && (rd_addr == rr_addr)));
    rr_data    = rr_ok ? eff_d[rr_addr] : '0;
  end

  srf_evt #(.DATA_W(DATA_W), .TID_W(TID_W), .RADDR_W(RADDR_W)) i_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_v      (ev_v),
    .ev_remote (ev_remote),
    .ev_tid    (cur_d[ev_addr][TID_W-1:0]),
    .ev_dest   (cur_d[ev_addr][RADDR_W-1:0]),
    .ev_data   (ev_data),
    .wake_v    (wake_v),
    .wake_tid  (wake_tid),
    .fwd_v     (fwd_v),
    .fwd_dest  (fwd_dest),
    .fwd_data  (fwd_data)
  );

endmodule

// File: rtl/srf_checker.sv
module srf_checker #(
  parameter int DATA_W   = 32,
  parameter int CTX_REGS = 32,
  parameter int ADDR_W   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_ok,
  input logic              rd_suspend,
  input logic              rd_err,
  input logic              rr_en,
  input logic [ADDR_W-1:0] rr_addr,
  input logic              rr_ok,
  input logic              rr_err,
  input logic              wb_en,
  input logic              aw_en,
  input logic              aw_held,
  input logic              wake_v,
  input logic              fwd_v
);

  localparam int IW = $clog2(CTX_REGS);
  localparam logic [IW-1:0] ZIDX = IW'(CTX_REGS - 1);

  p_read_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_ok, rd_suspend, rd_err}));

  p_remote_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rr_ok && rr_err));

  p_zero_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr[IW-1:0] == ZIDX) |-> (rd_ok && rd_data == '0));

  p_zero_remote_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_en && rr_addr[IW-1:0] == ZIDX) |-> rr_ok);

  p_hold_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aw_held) |-> $past(wb_en));

  p_no_aw_when_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    aw_held |-> !aw_en);

  p_wake_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wake_v |-> $past(wb_en || aw_en || aw_held));

  p_single_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wake_v && fwd_v));

endmodule

bind srf_top srf_checker #(
  .DATA_W(DATA_W), .CTX_REGS(CTX_REGS), .ADDR_W(ADDR_W)
) i_srf_checker (.*);

// File: tb/test_srf_top.sv
module test_srf_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_en, rr_en, wb_en, wb_empty, aw_en;
  logic [6:0]  rd_addr, rr_addr, wb_addr, aw_addr;
  logic [5:0]  rd_tid;
  logic [15:0] rr_dest;
  logic [31:0] wb_data, aw_data;
  logic [31:0] rd_data, rr_data, fwd_data;
  logic        rd_ok, rd_suspend, rd_err, rr_ok, rr_err, aw_held;
  logic        wake_v, fwd_v;
  logic [5:0]  wake_tid;
  logic [15:0] fwd_dest;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  srf_top i_srf_top (.*);

  // {address, write data, expected read}
  localparam logic [70:0] VEC [6] = '{
    {7'd1,   32'hDEADBEEF, 32'hDEADBEEF},
    {7'd2,   32'h00000000, 32'h00000000},
    {7'd33,  32'hFFFFFFFF, 32'hFFFFFFFF},
    {7'd95,  32'h12345678, 32'h00000000},
    {7'd127, 32'h00000001, 32'h00000000},
    {7'd100, 32'h80000000, 32'h80000000}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    rd_en = 0; rr_en = 0; wb_en = 0; aw_en = 0; wb_empty = 0;
    rd_addr = '0; rr_addr = '0; wb_addr = '0; aw_addr = '0;
    rd_tid = '0; rr_dest = '0; wb_data = '0; aw_data = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic lread(logic [6:0] a, logic [5:0] t);
    rd_en = 1; rd_addr = a; rd_tid = t; #1;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset state, R3 park thread 3 in reg 5
    lread(7'd5, 6'd3);
    chk("R1 suspend", {31'd0, rd_suspend}, 1);
    chk("R1 ok", {31'd0, rd_ok}, 0);
    chk("R1 wake idle", {31'd0, wake_v}, 0);
    tick();
    // R8 second reader rejected
    lread(7'd5, 6'd7);
    chk("R8 err", {31'd0, rd_err}, 1);
    tick();
    aw_en = 1; aw_addr = 7'd5; aw_data = 32'hCAFE;
    tick();
    chk("R3 wake", {31'd0, wake_v}, 1);
    chk("R8 kept tid", {26'd0, wake_tid}, 3);
    lread(7'd5, 6'd0);
    chk("R3 full data", rd_data, 32'hCAFE);
    tick();
    chk("R3 wake once", {31'd0, wake_v}, 0);

    // R4 remote continuation
    rr_en = 1; rr_addr = 7'd9; rr_dest = 16'h1234; #1;
    chk("R4 no ok", {30'd0, rr_ok, rr_err}, 0);
    tick();
    wb_en = 1; wb_addr = 7'd9; wb_data = 32'h55AA;
    tick();
    chk("R4 fwd_v", {31'd0, fwd_v}, 1);
    chk("R4 dest", {16'd0, fwd_dest}, 32'h1234);
    chk("R4 data", fwd_data, 32'h55AA);
    chk("R4 no wake", {31'd0, wake_v}, 0);
    // R5 remote read of full register
    rr_en = 1; rr_addr = 7'd9; #1;
    chk("R5 ok", {31'd0, rr_ok}, 1);
    chk("R5 data", rr_data, 32'h55AA);
    tick();

    // R6 set empty then async fill
    wb_en = 1; wb_addr = 7'd9; wb_empty = 1;
    tick();
    lread(7'd9, 6'd2);
    chk("R6 empty", {31'd0, rd_suspend}, 1);
    tick();
    aw_en = 1; aw_addr = 7'd9; aw_data = 32'h77;
    tick();
    chk("R6 wake tid", {25'd0, wake_v, wake_tid}, {25'd0, 1'b1, 6'd2});
    lread(7'd9, 6'd0);
    chk("R6 filled", rd_data, 32'h77);
    tick();

    // R7 same-address clash
    wb_en = 1; wb_addr = 7'd12; wb_data = 32'h111;
    aw_en = 1; aw_addr = 7'd12; aw_data = 32'h222;
    rd_en = 1; rd_addr = 7'd12; #1;
    chk("R7 wb first", rd_data, 32'h111);
    tick();
    chk("R7 held", {31'd0, aw_held}, 1);
    lread(7'd12, 6'd0);
    chk("R7 held applies", rd_data, 32'h222);
    tick();
    chk("R7 released", {31'd0, aw_held}, 0);
    lread(7'd12, 6'd0);
    chk("R7 final", rd_data, 32'h222);
    tick();

    // R7 two continuation events in one cycle
    lread(7'd20, 6'd4);
    tick();
    lread(7'd21, 6'd5);
    tick();
    wb_en = 1; wb_addr = 7'd20; wb_data = 32'hA0;
    aw_en = 1; aw_addr = 7'd21; aw_data = 32'hB1;
    tick();
    chk("R7 wb wake first", {25'd0, wake_v, wake_tid}, {25'd0, 1'b1, 6'd4});
    chk("R7 cont held", {31'd0, aw_held}, 1);
    tick();
    chk("R7 async wake next", {25'd0, wake_v, wake_tid}, {25'd0, 1'b1, 6'd5});

    // R9 zero register
    wb_en = 1; wb_addr = 7'd31; wb_data = 32'hFFFF;
    tick();
    aw_en = 1; aw_addr = 7'd63; aw_data = 32'h1;
    tick();
    lread(7'd31, 6'd1);
    chk("R9 zero after write", {rd_data[30:0], rd_ok}, 1);
    rr_en = 1; rr_addr = 7'd63; #1;
    chk("R9 remote zero", {rr_data[30:0], rr_ok}, 1);
    tick();

    // R10 bypass of a same-cycle write
    wb_en = 1; wb_addr = 7'd14; wb_data = 32'hABC;
    lread(7'd14, 6'd9);
    chk("R10 bypass", rd_data, 32'hABC);
    chk("R10 no suspend", {31'd0, rd_suspend}, 0);
    tick();
    chk("R10 no wake", {31'd0, wake_v}, 0);

    // R8 remote read of a thread continuation
    lread(7'd16, 6'd1);
    tick();
    rr_en = 1; rr_addr = 7'd16; rr_dest = 16'h9; #1;
    chk("R8 rr_err", {31'd0, rr_err}, 1);
    tick();
    aw_en = 1; aw_addr = 7'd16; aw_data = 32'h5;
    tick();
    chk("R8 wake kept", {24'd0, fwd_v, wake_v, wake_tid}, {24'd0, 1'b0, 1'b1, 6'd1});

    // R2 / R9 table walk
    for (int i = 0; i < 6; i++) begin
      wb_en = 1; wb_addr = VEC[i][70:64]; wb_data = VEC[i][63:32];
      tick();
      lread(VEC[i][70:64], 6'd0);
      chk("R2 R9 table ok", {31'd0, rd_ok}, 1);
      chk("R2 R9 table data", rd_data, VEC[i][31:0]);
      tick();
    end

    summary();
    $finish;
  end

endmodule